// File: doc/BRIEF.md
# Saturate and Bit-Search Execution Unit

This unit is one execution lane of a 32-bit processor and performs three operations. Two clamp a signed source word into a narrower signed range, either 16-bit or 24-bit. The clamped value is returned as a sign-extended 32-bit word for the register file. The third operation is a bit-search test. It shifts the source left by the low five bits of the destination operand and reports through the carry flag whether any bit survives.

Decode and the register file are outside the unit. The pipeline presents an operation code, both operands and the current flag word together with a one-cycle valid strobe. On the next clock edge the unit returns a registered result, a register write enable and the updated flag word. Saturation never changes the flags. Bit search changes only the carry flag and writes no register.

Top module: `satbs_unit`

## Requirements
- R1: With op code 0 (narrow clamp), a source above 0x00007FFF gives 0x00007FFF and a source below 0xFFFF8000 (as signed) gives 0xFFFF8000. Any other source passes through unchanged.
- R2: With op code 1 (wide clamp), a source above 0x007FFFFF gives 0x007FFFFF and a source below 0xFF800000 (as signed) gives 0xFF800000. Any other source passes through unchanged.
- R3: For op codes 0 and 1, `wr_en_o` is 1 and `flags_o` equals `flags_i`. The flag bits are Z=bit 0, N=bit 1, C=bit 2, V=bit 3.
- R4: With op code 2 (bit search), `flags_o` bit 2 is 1 exactly when `src_i` shifted left by `dst_i[4:0]` is nonzero in 32 bits. Bits 0, 1 and 3 are copied from `flags_i`. A shift of zero tests the unshifted source.
- R5: With op code 2, `wr_en_o` is 0 and `result_o` keeps the value it held before.
- R6: Op code 3 does nothing: `wr_en_o` is 0, `flags_o` equals `flags_i` and `result_o` keeps its value.
- R7: Outputs update only on a clock edge where `valid_i` is 1, and `done_o` is 1 in the following cycle. After an edge with `valid_i` 0, `done_o` and `wr_en_o` are 0 and `result_o` and `flags_o` hold.
- R8: While `rst_n` is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Issue strobe for one operation |
| op_i | input | 2 | Operation: 0 narrow clamp, 1 wide clamp, 2 bit search, 3 none |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand; low 5 bits are the shift for bit search |
| flags_i | input | 4 | Current flags {V,C,N,Z} |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Register write enable for the result |
| flags_o | output | 4 | Registered new flags {V,C,N,Z} |
| done_o | output | 1 | Outputs valid for one cycle after an issue |

## Verification
On every cycle the assertions check four things. A clamped result always sits inside its signed range. Saturation and the empty op code leave the flags as they arrived. Bit search never raises the write enable and keeps Z, N and V. An idle cycle changes nothing. The exact clamp boundaries, such as 0x7FFF passing while 0x8000 clamps, and the carry outcome for a given shift, including shifts that push the last set bit out, are shown only by the bench's vector table. The reset values and a result held across a bit search are also shown only by the bench.

// File: rtl/satbs_unit.sv
module satbs_unit #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [3:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [3:0]        flags_o,
  output logic              done_o
);
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int FLAG_C  = 2;
  localparam logic [1:0] OP_NARROW = 2'd0;
  localparam logic [1:0] OP_WIDE   = 2'd1;
  localparam logic [1:0] OP_SEARCH = 2'd2;

  localparam logic [DATA_W-1:0] NARROW_MAX = {{(DATA_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] WIDE_MAX   = {{(DATA_W-WIDE_W+1){1'b0}}, {(WIDE_W-1){1'b1}}};

  // in range when all bits at and above the target sign bit agree
  logic narrow_fits, wide_fits, neg;
  assign neg         = src_i[DATA_W-1];
  assign narrow_fits = (&src_i[DATA_W-1:NARROW_W-1]) | ~(|src_i[DATA_W-1:NARROW_W-1]);
  assign wide_fits   = (&src_i[DATA_W-1:WIDE_W-1])   | ~(|src_i[DATA_W-1:WIDE_W-1]);

  logic [DATA_W-1:0] narrow_val, wide_val;
  assign narrow_val = narrow_fits ? src_i : (neg ? ~NARROW_MAX : NARROW_MAX);
  assign wide_val   = wide_fits   ? src_i : (neg ? ~WIDE_MAX   : WIDE_MAX);

  logic [DATA_W-1:0] shifted;
  logic              any_left;
  assign shifted  = src_i << dst_i[SHAMT_W-1:0];
  assign any_left = |shifted;

  logic unused_dst_hi;
  assign unused_dst_hi = &{1'b0, dst_i[DATA_W-1:SHAMT_W]};

  logic is_sat;
  assign is_sat = (op_i == OP_NARROW) | (op_i == OP_WIDE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      flags_o  <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o  <= valid_i;
      wr_en_o <= valid_i & is_sat;
      if (valid_i) begin
        flags_o <= flags_i;
        if (op_i == OP_NARROW) result_o <= narrow_val;
        if (op_i == OP_WIDE)   result_o <= wide_val;
        if (op_i == OP_SEARCH) flags_o[FLAG_C] <= any_left;
      end
    end
  end
endmodule

// File: rtl/satbs_unit_chk.sv
module satbs_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [3:0]        flags_i,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic [3:0]        flags_o,
  input logic              done_o
);
  p_narrow_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'd0) |=> ((&result_o[DATA_W-1:NARROW_W-1]) || !(|result_o[DATA_W-1:NARROW_W-1])));

  p_wide_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'd1) |=> ((&result_o[DATA_W-1:WIDE_W-1]) || !(|result_o[DATA_W-1:WIDE_W-1])));

  p_sat_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i[1] == 1'b0) |=> (wr_en_o && flags_o == $past(flags_i)));

  p_search_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'd2) |=> (flags_o[0] == $past(flags_i[0]) && flags_o[1] == $past(flags_i[1])
                                   && flags_o[3] == $past(flags_i[3])));

  p_search_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'd2) |=> (!wr_en_o && $stable(result_o)));

  p_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'd3) |=> (!wr_en_o && $stable(result_o) && flags_o == $past(flags_i)));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!done_o && !wr_en_o && $stable(result_o) && $stable(flags_o)));

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> done_o);
endmodule

bind satbs_unit satbs_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .flags_i(flags_i),
  .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o), .done_o(done_o)
);

// File: tb/test_satbs_unit.sv
module test_satbs_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [1:0]  op_i;
  logic [31:0] src_i, dst_i;
  logic [3:0]  flags_i;
  logic [31:0] result_o;
  logic        wr_en_o, done_o;
  logic [3:0]  flags_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  satbs_unit i_satbs_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .src_i(src_i),
    .dst_i(dst_i), .flags_i(flags_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .flags_o(flags_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  op;
    logic [31:0] src;
    logic [31:0] dst;
    logic [3:0]  fin;
    logic        chk_res;
    logic [31:0] res;
    logic        we;
    logic [3:0]  fout;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{8'd1, 2'd0, 32'h0000_1234, 32'h0, 4'hF, 1'b1, 32'h0000_1234, 1'b1, 4'hF}, // R1 pass
    '{8'd1, 2'd0, 32'h0000_7FFF, 32'h0, 4'h0, 1'b1, 32'h0000_7FFF, 1'b1, 4'h0}, // R1 top edge
    '{8'd1, 2'd0, 32'h0000_8000, 32'h0, 4'h5, 1'b1, 32'h0000_7FFF, 1'b1, 4'h5}, // R1 clamp high
    '{8'd1, 2'd0, 32'hFFFF_8000, 32'h0, 4'hA, 1'b1, 32'hFFFF_8000, 1'b1, 4'hA}, // R1 low edge
    '{8'd1, 2'd0, 32'hFFFF_7FFF, 32'h0, 4'h3, 1'b1, 32'hFFFF_8000, 1'b1, 4'h3}, // R1 clamp low
    '{8'd1, 2'd0, 32'h8000_0000, 32'h0, 4'h0, 1'b1, 32'hFFFF_8000, 1'b1, 4'h0}, // R1 most negative
    '{8'd3, 2'd0, 32'h7FFF_FFFF, 32'h0, 4'hC, 1'b1, 32'h0000_7FFF, 1'b1, 4'hC}, // R3 flags kept
    '{8'd2, 2'd1, 32'h007F_FFFF, 32'h0, 4'h0, 1'b1, 32'h007F_FFFF, 1'b1, 4'h0}, // R2 top edge
    '{8'd2, 2'd1, 32'h0080_0000, 32'h0, 4'h9, 1'b1, 32'h007F_FFFF, 1'b1, 4'h9}, // R2 clamp high
    '{8'd2, 2'd1, 32'hFF80_0000, 32'h0, 4'h0, 1'b1, 32'hFF80_0000, 1'b1, 4'h0}, // R2 low edge
    '{8'd2, 2'd1, 32'hFF7F_FFFF, 32'h0, 4'h6, 1'b1, 32'hFF80_0000, 1'b1, 4'h6}, // R2 clamp low
    '{8'd2, 2'd1, 32'h0001_2345, 32'h0, 4'h0, 1'b1, 32'h0001_2345, 1'b1, 4'h0}, // R2 pass
    '{8'd3, 2'd1, 32'h8000_0000, 32'h0, 4'hF, 1'b1, 32'hFF80_0000, 1'b1, 4'hF}, // R3 flags kept
    '{8'd4, 2'd2, 32'h0000_0001, 32'h1F, 4'h0, 1'b0, 32'h0, 1'b0, 4'h4},        // R4 bit reaches top
    '{8'd4, 2'd2, 32'h0000_0002, 32'h1F, 4'hF, 1'b0, 32'h0, 1'b0, 4'hB},        // R4 bit pushed out
    '{8'd4, 2'd2, 32'h0000_0000, 32'h0,  4'h4, 1'b0, 32'h0, 1'b0, 4'h0},        // R4 zero source
    '{8'd4, 2'd2, 32'h0000_0005, 32'h0,  4'h0, 1'b0, 32'h0, 1'b0, 4'h4},        // R4 zero shift
    '{8'd4, 2'd2, 32'h0001_0000, 32'hFFFF_FFF0, 4'hD, 1'b0, 32'h0, 1'b0, 4'h9}, // R4 high dst bits ignored
    '{8'd5, 2'd2, 32'h0001_8000, 32'h30, 4'h3, 1'b0, 32'h0, 1'b0, 4'h7},        // R5 no write
    '{8'd6, 2'd3, 32'h1234_5678, 32'h7,  4'h6, 1'b0, 32'h0, 1'b0, 4'h6}         // R6 empty op
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] s, input logic [31:0] d, input logic [3:0] f);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; src_i = s; dst_i = d; flags_i = f;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; valid_i = 1'b0; op_i = 2'd0; src_i = '0; dst_i = '0; flags_i = '0;
    repeat (3) @(negedge clk);
    check("R8", "result", result_o, 32'h0);
    check("R8", "flags", {28'h0, flags_o}, 32'h0);
    check("R8", "we/done", {30'h0, wr_en_o, done_o}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i].req);
      held = result_o;
      issue(VEC[i].op, VEC[i].src, VEC[i].dst, VEC[i].fin);
      check(tag, $sformatf("v%0d flags", i), {28'h0, flags_o}, {28'h0, VEC[i].fout});
      check(tag, $sformatf("v%0d wr_en", i), {31'h0, wr_en_o}, {31'h0, VEC[i].we});
      check("R7", $sformatf("v%0d done", i), {31'h0, done_o}, 32'h1);
      if (VEC[i].chk_res)
        check(tag, $sformatf("v%0d result", i), result_o, VEC[i].res);
      else
        check(tag, $sformatf("v%0d result held", i), result_o, held);
    end

    // R5: result written by a clamp survives a later bit search
    issue(2'd0, 32'h0000_4321, 32'h0, 4'h0);
    issue(2'd2, 32'hFFFF_FFFF, 32'h3, 4'h0);
    check("R5", "result after search", result_o, 32'h0000_4321);
    check("R4", "carry after search", {28'h0, flags_o}, 32'h4);

    // R7: idle cycles with changing inputs change nothing
    @(negedge clk);
    op_i = 2'd1; src_i = 32'h7FFF_FFFF; flags_i = 4'hF;
    @(negedge clk);
    check("R7", "idle done", {31'h0, done_o}, 32'h0);
    check("R7", "idle wr_en", {31'h0, wr_en_o}, 32'h0);
    check("R7", "idle result", result_o, 32'h0000_4321);
    check("R7", "idle flags", {28'h0, flags_o}, 32'h4);

    // R8: reset in the middle of operation clears everything
    issue(2'd1, 32'h0000_0042, 32'h0, 4'hF);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8", "mid reset result", result_o, 32'h0);
    check("R8", "mid reset flags", {28'h0, flags_o}, 32'h0);
    check("R8", "mid reset we/done", {30'h0, wr_en_o, done_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule